// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one SDRAM read or write burst request into the stream of column addresses the burst visits, one address per clock. A controller pulses `start_i` with the first column and a 4-bit mode word. The low three mode bits select how many beats the burst has. The top bit selects sequential or XOR-interleaved ordering. From the following cycle the block presents one column per clock on `col_o`, qualified by `valid_o`, and marks the final beat of a finite burst with `last_o`.

In full-page mode the column address steps through the whole page, wraps at the top and keeps going. Such a burst ends only when the controller raises `stop_i`. A new `start_i` is accepted on any clock, including mid-burst. It drops the running sequence and restarts from the new column. Bank, row, refresh, data timing and command encoding are outside this block.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `mode_err_o` are 0 and `col_o` is 0.
- R2: In the cycle after `start_i` is sampled high, `valid_o` is 1 and `col_o` equals the sampled `start_col_i`.
- R3: `mode_i[2:0]` sets the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. A finite burst holds `valid_o` for exactly that many cycles, with `last_o` high only on the final beat, and `valid_o` falls in the cycle after it.
- R4: With `mode_i[3]`=0 and BL beats, beat n carries the start column with its low log2(BL) bits replaced by (start + n) mod BL; the upper bits keep their start value.
- R5: With `mode_i[3]`=1 and a length of 4 or 8, beat n carries the start column with its low log2(BL) bits XORed with n.
- R6: With `mode_i[3]`=1 and a length of 1 or 2, the sequence is identical to the sequential one.
- R7: With `mode_i[2:0]`=111 (full page), each beat is the previous column plus one modulo 2^COL_W, the burst never ends on its own and `last_o` stays 0.
- R8: `stop_i` high during a burst makes `valid_o` 0 in the next cycle. `stop_i` has no effect while idle or in a cycle where `start_i` is high.
- R9: A `start_i` during a running burst abandons it; the next cycle shows beat 0 of the new burst.
- R10: The reserved length codes 100, 101 and 110 give a 1-beat burst. `mode_err_o` is 1 from the cycle after that start until the next start.
- R11: `mode_i` and `start_col_i` are sampled only with `start_i`. Changes to them during a burst do not alter its addresses or length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst with the current column and mode |
| start_col_i | input | COL_W | First column of the burst |
| mode_i | input | 4 | Bit 3 ordering (0 sequential, 1 interleaved); bits 2:0 length code |
| stop_i | input | 1 | End the running burst after the current beat |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A burst beat is being presented |
| last_o | output | 1 | Current beat is the final one of a finite burst |
| mode_err_o | output | 1 | The last start used a reserved length code |

## Verification
The checker enforces several rules on every cycle. A start loads its column in the next cycle. A beat flagged last, or a stop, ends the burst. An idle block stays idle without a start. A full-page burst steps by exactly one and never flags a last beat. The upper column bits hold steady within a finite burst. A reserved code yields a flagged single beat. The exact beat order of sequential and interleaved bursts, the equivalence of the two orderings at short lengths, and the count of beats per length code are compared against bench-computed sequences. The same comparison covers the restart and stop timing and the insensitivity to mode and column changes mid-burst.

// File: rtl/burst_pkg.sv
package burst_pkg;

   localparam int unsigned MODE_W     = 4;
   localparam int unsigned BURST_BITS = 3;   // log2 of the longest finite burst

   typedef struct packed {
      logic [1:0] len_log2;    // log2 of finite burst length
      logic       interleave;  // XOR ordering in effect
      logic       full_page;   // wrap through the page, no natural end
      logic       reserved;    // length code was not a defined one
   } burst_mode_t;

   function automatic burst_mode_t decode_burst_mode(input logic [MODE_W-1:0] m);
      burst_mode_t d;
      d = '0;
      unique case (m[2:0])
         3'b000:  d.len_log2 = 2'd0;
         3'b001:  d.len_log2 = 2'd1;
         3'b010:  d.len_log2 = 2'd2;
         3'b011:  d.len_log2 = 2'd3;
         3'b111:  d.full_page = 1'b1;
         default: d.reserved = 1'b1;
      endcase
      // XOR ordering only differs from counting at lengths of four and up
      d.interleave = m[3] && !d.full_page && (d.len_log2 >= 2'd2);
      return d;
   endfunction

   function automatic logic [BURST_BITS-1:0] final_beat(input logic [1:0] len_log2);
      return BURST_BITS'((4'd1 << len_log2) - 4'd1);
   endfunction

endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec
   import burst_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [MODE_W-1:0] mode_i,
   output burst_mode_t       live_o,
   output burst_mode_t       cfg_o
);

   assign live_o = decode_burst_mode(mode_i);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cfg_o <= '0;
      else if (load_i)
         cfg_o <= live_o;
   end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
   import burst_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load_i,
   input  logic                  stop_i,
   input  burst_mode_t           live_i,
   input  burst_mode_t           cfg_i,
   output logic                  active_o,
   output logic                  adv_o,
   output logic [BURST_BITS-1:0] beat_o,
   output logic                  last_o
);

   logic [BURST_BITS-1:0] beat_nxt;

   assign beat_nxt = beat_o + 1'b1;
   assign adv_o    = active_o && !stop_i && !last_o && !load_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_o <= 1'b0;
         beat_o   <= '0;
         last_o   <= 1'b0;
      end else if (load_i) begin
         active_o <= 1'b1;
         beat_o   <= '0;
         last_o   <= !live_i.full_page && (live_i.len_log2 == 2'd0);
      end else if (active_o) begin
         if (stop_i || last_o) begin
            active_o <= 1'b0;
            last_o   <= 1'b0;
         end else begin
            beat_o   <= beat_nxt;
            last_o   <= !cfg_i.full_page && (beat_nxt == final_beat(cfg_i.len_log2));
         end
      end
   end

endmodule

// File: rtl/burst_addr_unit.sv
module burst_addr_unit
   import burst_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load_i,
   input  logic                  adv_i,
   input  logic [COL_W-1:0]      start_col_i,
   input  burst_mode_t           cfg_i,
   input  logic [BURST_BITS-1:0] beat_i,
   output logic [COL_W-1:0]      col_o
);

   logic [COL_W-1:0]      base_q;
   logic [COL_W-1:0]      col_nxt;
   logic [COL_W-1:0]      col_inc;
   logic [BURST_BITS-1:0] step;
   logic [BURST_BITS-1:0] seq_low;
   logic [BURST_BITS-1:0] xor_low;

   assign col_inc = col_o + 1'b1;
   assign step    = beat_i + 1'b1;
   assign seq_low = base_q[BURST_BITS-1:0] + step;
   assign xor_low = base_q[BURST_BITS-1:0] ^ step;

   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      if (i < BURST_BITS) begin : g_field
         // bit can sit inside the wrapping burst field
         logic in_field;
         assign in_field   = (2'(i) < cfg_i.len_log2);
         assign col_nxt[i] = cfg_i.full_page ? col_inc[i] :
                             !in_field       ? base_q[i]  :
                             cfg_i.interleave ? xor_low[i] : seq_low[i];
      end else begin : g_upper
         // bit only moves when the whole page is being swept
         assign col_nxt[i] = cfg_i.full_page ? col_inc[i] : base_q[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         col_o  <= '0;
      end else if (load_i) begin
         base_q <= start_col_i;
         col_o  <= start_col_i;
      end else if (adv_i) begin
         col_o  <= col_nxt;
      end
   end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
   import burst_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [COL_W-1:0]  start_col_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              stop_i,
   output logic [COL_W-1:0]  col_o,
   output logic              valid_o,
   output logic              last_o,
   output logic              mode_err_o
);

   if (COL_W < BURST_BITS + 1 || COL_W > 24) begin : g_bad_width
      $error("burst_col_gen: COL_W must lie between BURST_BITS+1 and 24");
   end

   burst_mode_t           live_w;
   burst_mode_t           cfg_q;
   logic                  adv_w;
   logic [BURST_BITS-1:0] beat_w;
   logic                  full_page_w;

   burst_mode_dec u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (start_i),
      .mode_i (mode_i),
      .live_o (live_w),
      .cfg_o  (cfg_q)
   );

   burst_beat_ctr u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (start_i),
      .stop_i   (stop_i),
      .live_i   (live_w),
      .cfg_i    (cfg_q),
      .active_o (valid_o),
      .adv_o    (adv_w),
      .beat_o   (beat_w),
      .last_o   (last_o)
   );

   burst_addr_unit #(.COL_W(COL_W)) u_addr (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (start_i),
      .adv_i       (adv_w),
      .start_col_i (start_col_i),
      .cfg_i       (cfg_q),
      .beat_i      (beat_w),
      .col_o       (col_o)
   );

   assign mode_err_o  = cfg_q.reserved;
   assign full_page_w = cfg_q.full_page;

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
   parameter int unsigned COL_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [COL_W-1:0] start_col_i,
   input logic [3:0]       mode_i,
   input logic             stop_i,
   input logic [COL_W-1:0] col_o,
   input logic             valid_o,
   input logic             last_o,
   input logic             mode_err_o,
   input logic             full_page
);

   logic rsv_code;
   assign rsv_code = (mode_i[2:0] == 3'b100) || (mode_i[2:0] == 3'b101) ||
                     (mode_i[2:0] == 3'b110);

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (valid_o && col_o == $past(start_col_i)));

   p_last_in_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   p_end_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !valid_o);

   p_upper_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !full_page && !start_i && !stop_i && !last_o) |=>
      (col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));

   p_page_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && full_page && !start_i && !stop_i) |=>
      (valid_o && col_o == COL_W'($past(col_o) + 1'b1)));

   p_page_no_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && full_page) |-> !last_o);

   p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && stop_i && !start_i) |=> !valid_o);

   p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_o && !start_i) |=> !valid_o);

   p_reserved_one_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && rsv_code) |=> (last_o && mode_err_o));

   p_err_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(mode_err_o));

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .start_col_i (start_col_i),
   .mode_i      (mode_i),
   .stop_i      (stop_i),
   .col_o       (col_o),
   .valid_o     (valid_o),
   .last_o      (last_o),
   .mode_err_o  (mode_err_o),
   .full_page   (full_page_w)
);

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;

   localparam int COL_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [COL_W-1:0] start_col_i = '0;
   logic [3:0]       mode_i = '0;
   logic             stop_i = 1'b0;
   logic [COL_W-1:0] col_o;
   logic             valid_o;
   logic             last_o;
   logic             mode_err_o;

   int    checks = 0;
   int    failures = 0;
   bit    done = 1'b0;
   string tag_over = "";

   always #4 clk = ~clk;   // 125 MHz

   burst_col_gen #(.COL_W(COL_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
      .mode_i(mode_i), .stop_i(stop_i), .col_o(col_o), .valid_o(valid_o),
      .last_o(last_o), .mode_err_o(mode_err_o));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit is_rsv(input logic [3:0] m);
      return m[2:0] == 3'b100 || m[2:0] == 3'b101 || m[2:0] == 3'b110;
   endfunction

   function automatic int len_of(input logic [3:0] m);
      case (m[2:0])
         3'b001: return 2;
         3'b010: return 4;
         3'b011: return 8;
         default: return 1;
      endcase
   endfunction

   function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s,
                                               input logic [3:0] m, input int n);
      logic [COL_W-1:0] mask, low;
      if (m[2:0] == 3'b111) return COL_W'(int'(s) + n);
      mask = COL_W'(len_of(m) - 1);
      if (m[3] && len_of(m) >= 4) low = (s ^ COL_W'(n)) & mask;
      else                        low = COL_W'(int'(s) + n) & mask;
      return (s & ~mask) | low;
   endfunction

   function automatic string col_tag(input logic [3:0] m);
      if (tag_over != "")       return tag_over;
      if (m[2:0] == 3'b111)     return "R7";
      if (is_rsv(m))            return "R10";
      if (m[3] && len_of(m) >= 4) return "R5";
      if (m[3])                 return "R6";
      return "R4";
   endfunction

   // stop_at: beat at which stop_i is raised (-1 none); abandon_at: return early
   task automatic run_burst(input logic [COL_W-1:0] s, input logic [3:0] m,
                            input int stop_at, input int abandon_at);
      bit fp;
      int bl;
      fp = (m[2:0] == 3'b111);
      bl = len_of(m);
      @(negedge clk);
      start_i = 1'b1; start_col_i = s; mode_i = m; stop_i = 1'b0;
      for (int n = 0; ; n++) begin
         @(negedge clk);
         start_i = 1'b0;
         start_col_i = COL_W'($urandom);   // R11: junk while the burst runs
         mode_i = 4'($urandom);
         chk(n == 0 ? (tag_over != "" ? tag_over : "R2") : "R3", int'(valid_o), 1);
         chk(col_tag(m), int'(col_o), int'(exp_col(s, m, n)));
         chk(fp ? "R7" : "R3", int'(last_o), int'(!fp && n == bl - 1));
         chk("R10", int'(mode_err_o), int'(is_rsv(m)));
         if (n == abandon_at) return;
         if (n == stop_at) begin
            stop_i = 1'b1;
            @(negedge clk);
            stop_i = 1'b0;
            chk("R8", int'(valid_o), 0);
            return;
         end
         if (!fp && n == bl - 1) begin
            @(negedge clk);
            chk("R3", int'(valid_o), 0);
            return;
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", int'(valid_o), 0);
      chk("R1", int'(last_o), 0);
      chk("R1", int'(mode_err_o), 0);
      chk("R1", int'(col_o), 0);

      // R3 R4: each defined length, sequential
      run_burst(8'hA5, 4'b0000, -1, -1);
      run_burst(8'hA5, 4'b0001, -1, -1);
      run_burst(8'hA5, 4'b0010, -1, -1);
      run_burst(8'hA5, 4'b0011, -1, -1);
      run_burst(8'h3E, 4'b0011, -1, -1);
      // R5: interleaved at 4 and 8
      run_burst(8'hA5, 4'b1010, -1, -1);
      run_burst(8'h6B, 4'b1011, -1, -1);
      // R6: interleaved at 1 and 2
      run_burst(8'hA5, 4'b1000, -1, -1);
      run_burst(8'hA7, 4'b1001, -1, -1);
      // R7: full page sweeps past the top of the page
      run_burst(8'hF0, 4'b0111, 300, -1);
      run_burst(8'hFE, 4'b1111, 5, -1);
      // R10: reserved codes, then a defined code clears the flag
      run_burst(8'h12, 4'b0100, -1, -1);
      run_burst(8'h34, 4'b1101, -1, -1);
      run_burst(8'h56, 4'b0110, -1, -1);
      run_burst(8'h78, 4'b0010, -1, -1);
      // R8: stop in the middle of an 8-beat burst
      run_burst(8'h20, 4'b1011, 3, -1);
      // R8: stop while idle is ignored
      @(negedge clk); stop_i = 1'b1;
      @(negedge clk); stop_i = 1'b0;
      chk("R8", int'(valid_o), 0);
      // R8: start wins over a simultaneous stop
      start_i = 1'b1; stop_i = 1'b1; start_col_i = 8'h44; mode_i = 4'b0001;
      @(negedge clk);
      start_i = 1'b0; stop_i = 1'b0;
      chk("R8", int'(valid_o), 1);
      chk("R8", int'(col_o), 8'h44);
      @(negedge clk);
      chk("R8", int'(col_o), 8'h45);
      @(negedge clk);
      chk("R8", int'(valid_o), 0);
      // R9: restart in mid-burst
      run_burst(8'h90, 4'b0011, -1, 2);
      tag_over = "R9";
      run_burst(8'h0D, 4'b1010, -1, -1);
      tag_over = "";
      // R11: inputs scrambled during an interleaved 8-beat burst
      tag_over = "R11";
      run_burst(8'hC3, 4'b1011, -1, -1);
      tag_over = "";

      // constrained random bursts
      for (int k = 0; k < 200; k++) begin
         logic [3:0] m;
         int         sa;
         m  = 4'($urandom);
         sa = -1;
         if (m[2:0] == 3'b111) sa = int'($urandom % 40);
         else if ($urandom % 4 == 0) sa = int'($urandom % len_of(m));
         run_burst(COL_W'($urandom), m, sa, -1);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule